// File: doc/BRIEF.md
# Serial NOR Flash Slave Emulator

This block behaves as the slave end of a serial NOR flash on an SPI bus, implemented in synthesizable logic that runs on a fast system clock. The clock, chip-select and data-in lines are oversampled. Every transaction opens with an instruction byte, which may be followed by address, dummy and data bytes. Behind the bus sits a small byte array that stands in for the flash cells. A timer that counts system clocks models the time a program or erase cycle takes.

The block serves a host controller or driver under test that needs a flash it can fully observe. It handles reads, write enable, page program, sector erase, status polling, a parameter-discovery table read and a deep power-down state. Program and erase take effect only when chip select rises exactly on a byte boundary. While an internal cycle runs, commands that touch the array are dropped. The array, page and sector sizes are parameters. The defaults are a 512-byte array, 32-byte pages and 128-byte sectors.

Top module: `spi_flash_emu`

## Requirements
- R1: The bus works in mode 0 (clock idles low) and in mode 3 (clock idles high). Input bits are taken MSB first on rising SCK edges. Output bits change after falling edges, MSB first.
- R2: Read (0x03) takes three address bytes and then returns array bytes from that address, using the low address bits. It continues past the top byte to address 0 for as long as chip select stays low.
- R3: Read-status (0x05) returns the status byte repeatedly until chip select rises. Bit 0 is the busy flag, bit 1 is the write-enable latch, and bits 7 to 2 are always 0.
- R4: Write-enable (0x06) sets the latch only when chip select rises after exactly 8 bits.
- R5: Page program (0x02, three address bytes, data) ANDs each data byte into the array. The first byte goes to the addressed offset, and the offset wraps inside the page. The program is carried out only when chip select rises on a byte boundary after at least one data byte. Otherwise nothing changes and the latch stays set.
- R6: Sector erase (0x20, three address bytes) sets the whole addressed sector to 0xFF. It is carried out only when chip select rises right after the third address byte. Other sectors are untouched.
- R7: Program and erase are dropped when the write-enable latch is clear.
- R8: Once a program or erase is accepted, the busy flag stays 1 for max(BUSY_CYCLES, sector size) system clocks. When it falls, the write-enable latch is 0.
- R9: While busy, every instruction except read-status is ignored. MISO stays 0 and the array does not change.
- R10: Discovery read (0x5A) takes three address bytes and one dummy byte, then returns table bytes with an incrementing address. Addresses 0 to 3 give 0x53, 0x46, 0x44, 0x50. Any other address gives its own low address byte.
- R11: After power-down (0xB9), every instruction except release (0xAB) is ignored, and MISO stays 0. Release returns the block to normal operation.
- R12: After reset, the status is 0x00, every array byte is 0xFF and MISO is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used for oversampling |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | SPI serial clock |
| csn_i | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | SPI data from the host |
| miso_o | output | 1 | SPI data to the host |

## Verification
The hardest situations to reach from the pins are the ones where chip select rises mid-byte, and the ones where a command lands inside a running program or erase cycle. The stimulus reaches the first kind with a bit-level send task that stops after an arbitrary number of bits: after 7 or 9 bits of write-enable, after 3 bits of a program data byte, and after 2 bits past an erase address. In each case the bench then reads the status and the array to confirm nothing happened. It reaches the second kind by setting the busy time far longer than a few bus bytes, issuing a read and a program immediately after an erase is accepted, and checking both MISO and the later array contents.

// File: rtl/spi_flash_pkg.sv
package spi_flash_pkg;
  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_DUMMY, ST_DATA, ST_STAT, ST_ONE, ST_ARMED, ST_IGN
  } cmd_st_e;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE   = 8'h20;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_DISC = 8'h5A;
  localparam logic [7:0] OP_PD   = 8'hB9;
  localparam logic [7:0] OP_REL  = 8'hAB;

  function automatic logic [7:0] disc_byte(input logic [23:0] a);
    case (a)
      24'd0:   disc_byte = 8'h53;
      24'd1:   disc_byte = 8'h46;
      24'd2:   disc_byte = 8'h44;
      24'd3:   disc_byte = 8'h50;
      default: disc_byte = a[7:0];
    endcase
  endfunction
endpackage

// File: rtl/spi_flash_phy.sv
module spi_flash_phy (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sck_i,
  input  logic       csn_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_byte_i,
  output logic       miso_o,
  output logic       byte_vld_o,
  output logic [7:0] rx_byte_o,
  output logic       cs_fall_o,
  output logic       cs_rise_o,
  output logic       on_bound_o
);
  logic [2:0] sck_q, cs_q;
  logic [1:0] mosi_q;
  logic [2:0] bit_cnt;
  logic [6:0] rx_sh, tx_sh;
  logic       miso_q, sck_rise, sck_fall, cs_s;

  assign cs_s     = cs_q[1];
  assign sck_rise = sck_q[1] & ~sck_q[2] & ~cs_s;
  assign sck_fall = ~sck_q[1] & sck_q[2] & ~cs_s;

  assign cs_fall_o  = ~cs_s & cs_q[2];
  assign cs_rise_o  = cs_s & ~cs_q[2];
  assign on_bound_o = (bit_cnt == 3'd0);
  assign byte_vld_o = sck_rise && bit_cnt == 3'd7;
  assign rx_byte_o  = {rx_sh, mosi_q[1]};
  assign miso_o     = miso_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q   <= '0;
      cs_q    <= '1;
      mosi_q  <= '0;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      miso_q  <= 1'b0;
    end else begin
      sck_q  <= {sck_q[1:0], sck_i};
      cs_q   <= {cs_q[1:0], csn_i};
      mosi_q <= {mosi_q[0], mosi_i};
      if (cs_fall_o) bit_cnt <= '0;
      else if (sck_rise) begin
        rx_sh   <= {rx_sh[5:0], mosi_q[1]};
        bit_cnt <= bit_cnt + 3'd1;
      end
      if (cs_s) miso_q <= 1'b0;
      else if (sck_fall) begin
        if (bit_cnt == 3'd0) begin
          miso_q <= tx_byte_i[7];
          tx_sh  <= tx_byte_i[6:0];
        end else begin
          miso_q <= tx_sh[6];
          tx_sh  <= {tx_sh[5:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_flash_ctrl.sv
module spi_flash_ctrl
  import spi_flash_pkg::*;
#(
  parameter int ADDR_W = 9,
  parameter int PAGE_W = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     byte_vld_i,
  input  logic [7:0]               rx_byte_i,
  input  logic                     cs_fall_i,
  input  logic                     cs_rise_i,
  input  logic                     on_bound_i,
  input  logic                     busy_i,
  input  logic                     done_i,
  input  logic [7:0]               rd_data_i,
  output logic [7:0]               tx_byte_o,
  output logic [ADDR_W-1:0]        rd_addr_o,
  output logic [ADDR_W-PAGE_W-1:0] op_page_o,
  output logic                     buf_clr_o,
  output logic                     buf_we_o,
  output logic [PAGE_W-1:0]        buf_off_o,
  output logic [7:0]               buf_data_o,
  output logic                     start_pp_o,
  output logic                     start_se_o,
  output logic                     wel_o,
  output logic                     pd_o
);
  cmd_st_e     st;
  logic [7:0]  op;
  logic [23:0] addr;
  logic [1:0]  acnt;
  logic        wel, pd, pp_any, commit;

  assign commit     = cs_rise_i && on_bound_i;
  assign start_pp_o = commit && st == ST_DATA && op == OP_PP && pp_any;
  assign start_se_o = commit && st == ST_ARMED;
  assign buf_we_o   = byte_vld_i && st == ST_DATA && op == OP_PP;
  assign buf_clr_o  = byte_vld_i && st == ST_ADDR && acnt == 2'd2 && op == OP_PP;
  assign buf_off_o  = addr[PAGE_W-1:0];
  assign buf_data_o = rx_byte_i;
  assign rd_addr_o  = addr[ADDR_W-1:0];
  assign op_page_o  = addr[ADDR_W-1:PAGE_W];
  assign wel_o      = wel;
  assign pd_o       = pd;

  always_comb begin
    tx_byte_o = 8'h00;
    if (st == ST_STAT) tx_byte_o = {6'b0, wel, busy_i};
    else if (st == ST_DATA && op == OP_READ) tx_byte_o = rd_data_i;
    else if (st == ST_DATA && op == OP_DISC) tx_byte_o = disc_byte(addr);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IGN; op <= '0; addr <= '0; acnt <= '0;
      wel <= 1'b0; pd <= 1'b0; pp_any <= 1'b0;
    end else begin
      if (done_i) wel <= 1'b0;
      if (cs_fall_i) begin
        st     <= ST_OPC;
        pp_any <= 1'b0;
      end else if (byte_vld_i) begin
        unique case (st)
          ST_OPC: begin
            op   <= rx_byte_i;
            acnt <= '0;
            if (pd) st <= (rx_byte_i == OP_REL) ? ST_ONE : ST_IGN;
            else if (busy_i) st <= (rx_byte_i == OP_RDSR) ? ST_STAT : ST_IGN;
            else begin
              case (rx_byte_i)
                OP_WREN, OP_PD:   st <= ST_ONE;
                OP_READ, OP_DISC: st <= ST_ADDR;
                OP_PP, OP_SE:     st <= wel ? ST_ADDR : ST_IGN;
                OP_RDSR:          st <= ST_STAT;
                default:          st <= ST_IGN;
              endcase
            end
          end
          ST_ADDR: begin
            addr <= {addr[15:0], rx_byte_i};
            acnt <= acnt + 2'd1;
            if (acnt == 2'd2)
              st <= (op == OP_DISC) ? ST_DUMMY : (op == OP_SE) ? ST_ARMED : ST_DATA;
          end
          ST_DUMMY: st <= ST_DATA;
          ST_DATA: begin
            if (op == OP_PP) begin
              pp_any <= 1'b1;
              addr[PAGE_W-1:0] <= addr[PAGE_W-1:0] + 1'b1;
            end else addr <= addr + 24'd1;
          end
          ST_ONE, ST_ARMED: st <= ST_IGN;
          default: ;
        endcase
      end else if (commit && st == ST_ONE) begin
        case (op)
          OP_WREN: wel <= 1'b1;
          OP_PD:   pd  <= 1'b1;
          OP_REL:  pd  <= 1'b0;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_flash_array.sv
module spi_flash_array #(
  parameter int ADDR_W   = 9,
  parameter int PAGE_W   = 5,
  parameter int SECTOR_W = 7,
  parameter int BUSY_LEN = 1000
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [ADDR_W-1:0]        rd_addr_i,
  output logic [7:0]               rd_data_o,
  input  logic [ADDR_W-PAGE_W-1:0] op_page_i,
  input  logic                     buf_clr_i,
  input  logic                     buf_we_i,
  input  logic [PAGE_W-1:0]        buf_off_i,
  input  logic [7:0]               buf_data_i,
  input  logic                     start_pp_i,
  input  logic                     start_se_i,
  output logic                     busy_o,
  output logic                     done_o
);
  localparam int MEM_BYTES  = 1 << ADDR_W;
  localparam int PAGE_BYTES = 1 << PAGE_W;
  localparam int CNT_W      = $clog2(BUSY_LEN + 1);
  localparam logic [CNT_W-1:0] PAGE_LIM = CNT_W'(PAGE_BYTES);
  localparam logic [CNT_W-1:0] SEC_LIM  = CNT_W'(1 << SECTOR_W);
  localparam logic [CNT_W-1:0] LAST     = CNT_W'(BUSY_LEN - 1);

  logic [7:0]               mem    [MEM_BYTES];
  logic [7:0]               pg_buf [PAGE_BYTES];
  logic [PAGE_BYTES-1:0]    pg_val;
  logic [ADDR_W-PAGE_W-1:0] base;
  logic [CNT_W-1:0]         cnt;
  logic                     run, mode_se;
  logic [ADDR_W-1:0]        pp_a, se_a;

  assign rd_data_o = mem[rd_addr_i];
  assign busy_o    = run;
  assign done_o    = run && cnt == LAST;
  assign pp_a      = {base, cnt[PAGE_W-1:0]};
  assign se_a      = {base[ADDR_W-PAGE_W-1:SECTOR_W-PAGE_W], cnt[SECTOR_W-1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= 8'hFF;
      for (int j = 0; j < PAGE_BYTES; j++) pg_buf[j] <= 8'hFF;
      pg_val <= '0; base <= '0; cnt <= '0; run <= 1'b0; mode_se <= 1'b0;
    end else begin
      if (buf_clr_i) pg_val <= '0;
      if (buf_we_i) begin
        pg_buf[buf_off_i] <= buf_data_i;
        pg_val[buf_off_i] <= 1'b1;
      end
      if (start_pp_i || start_se_i) begin
        run     <= 1'b1;
        cnt     <= '0;
        mode_se <= start_se_i;
        base    <= op_page_i;
      end else if (run) begin
        // one byte per clock while the busy window runs
        if (mode_se && cnt < SEC_LIM) mem[se_a] <= 8'hFF;
        if (!mode_se && cnt < PAGE_LIM && pg_val[cnt[PAGE_W-1:0]])
          mem[pp_a] <= mem[pp_a] & pg_buf[cnt[PAGE_W-1:0]];
        cnt <= cnt + 1'b1;
        if (cnt == LAST) run <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_flash_emu.sv
module spi_flash_emu #(
  parameter int ADDR_W      = 9,
  parameter int PAGE_W      = 5,
  parameter int SECTOR_W    = 7,
  parameter int BUSY_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sck_i,
  input  logic csn_i,
  input  logic mosi_i,
  output logic miso_o
);
  localparam int SECTOR_BYTES = 1 << SECTOR_W;
  localparam int BUSY_LEN = (BUSY_CYCLES > SECTOR_BYTES) ? BUSY_CYCLES : SECTOR_BYTES;

  logic [7:0]               tx_byte, rx_byte, rd_data, buf_data;
  logic                     byte_vld, cs_fall, cs_rise, on_bound;
  logic                     busy, done, buf_clr, buf_we, start_pp, start_se, wel, pd;
  logic [ADDR_W-1:0]        rd_addr;
  logic [ADDR_W-PAGE_W-1:0] op_page;
  logic [PAGE_W-1:0]        buf_off;

  spi_flash_phy u_phy (
    .clk_i, .rst_ni, .sck_i, .csn_i, .mosi_i,
    .tx_byte_i(tx_byte), .miso_o, .byte_vld_o(byte_vld), .rx_byte_o(rx_byte),
    .cs_fall_o(cs_fall), .cs_rise_o(cs_rise), .on_bound_o(on_bound)
  );

  spi_flash_ctrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctrl (
    .clk_i, .rst_ni,
    .byte_vld_i(byte_vld), .rx_byte_i(rx_byte), .cs_fall_i(cs_fall),
    .cs_rise_i(cs_rise), .on_bound_i(on_bound), .busy_i(busy), .done_i(done),
    .rd_data_i(rd_data), .tx_byte_o(tx_byte), .rd_addr_o(rd_addr),
    .op_page_o(op_page), .buf_clr_o(buf_clr), .buf_we_o(buf_we),
    .buf_off_o(buf_off), .buf_data_o(buf_data), .start_pp_o(start_pp),
    .start_se_o(start_se), .wel_o(wel), .pd_o(pd)
  );

  spi_flash_array #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECTOR_W(SECTOR_W), .BUSY_LEN(BUSY_LEN)
  ) u_array (
    .clk_i, .rst_ni, .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .op_page_i(op_page), .buf_clr_i(buf_clr), .buf_we_i(buf_we),
    .buf_off_i(buf_off), .buf_data_i(buf_data), .start_pp_i(start_pp),
    .start_se_i(start_se), .busy_o(busy), .done_o(done)
  );
endmodule

// File: rtl/spi_flash_emu_chk.sv
module spi_flash_emu_chk #(
  parameter int BUSY_LEN = 1000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic busy,
  input logic wel,
  input logic pd,
  input logic start_pp,
  input logic start_se
);
  int unsigned bcnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bcnt <= 0;
    else bcnt <= busy ? bcnt + 1 : 0;
  end

  p_busy_len_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> bcnt == BUSY_LEN);
  p_wel_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> !wel);
  p_wel_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_pp || start_se) |-> wel);
  p_idle_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_pp || start_se) |-> !busy);
  p_pd_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd |-> !(start_pp || start_se));
  p_pd_wel_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd && $past(pd)) |-> $stable(wel));
endmodule

bind spi_flash_emu spi_flash_emu_chk #(.BUSY_LEN(BUSY_LEN)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy(busy), .wel(wel), .pd(pd),
  .start_pp(start_pp), .start_se(start_se)
);

// File: tb/spi_flash_emu_tb_top.sv
`timescale 1ns/1ps
module spi_flash_emu_tb_top;
  localparam int  HP  = 40;
  localparam int  WDOG_CYC = 190000;

  logic clk_i = 1'b0, rst_ni = 1'b0, sck = 1'b0, csn = 1'b1, mosi = 1'b0, miso;
  logic mode3 = 1'b0;
  logic [7:0] rb [8];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  spi_flash_emu #(.ADDR_W(9), .PAGE_W(5), .SECTOR_W(7), .BUSY_CYCLES(2000)) dut_i (
    .clk_i, .rst_ni, .sck_i(sck), .csn_i(csn), .mosi_i(mosi), .miso_o(miso)
  );

  // {mode3, address, expected}
  localparam logic [32:0] VEC [6] = '{
    {1'b0, 24'h000000, 8'h53}, {1'b1, 24'h000001, 8'h46},
    {1'b0, 24'h000002, 8'h44}, {1'b1, 24'h000003, 8'h50},
    {1'b0, 24'h000010, 8'h10}, {1'b1, 24'h0123AB, 8'hAB}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cs_lo();
    sck = mode3; #HP; csn = 1'b0; #HP;
  endtask

  task automatic cs_hi();
    if (!mode3) begin sck = 1'b0; #HP; end
    csn = 1'b1; #(2*HP); sck = mode3; #HP;
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      sck = 1'b0; mosi = tx[i]; #HP;
      rx[i] = miso; sck = 1'b1; #HP;
    end
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    xbits(tx, 8, rx);
  endtask

  task automatic send_addr(input logic [23:0] a);
    logic [7:0] d;
    xfer(a[23:16], d); xfer(a[15:8], d); xfer(a[7:0], d);
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] d;
    cs_lo(); xfer(op, d); cs_hi();
  endtask

  task automatic rdsr(output logic [7:0] s);
    logic [7:0] d;
    cs_lo(); xfer(8'h05, d); xfer(8'h00, s); cs_hi();
  endtask

  task automatic rd(input logic [7:0] op, input logic [23:0] a, input int n);
    logic [7:0] d;
    cs_lo(); xfer(op, d); send_addr(a);
    if (op == 8'h5A) xfer(8'h00, d);
    for (int i = 0; i < n; i++) xfer(8'h00, rb[i]);
    cs_hi();
  endtask

  task automatic pp(input logic [23:0] a, input logic [31:0] dat, input int n);
    logic [7:0] d;
    cs_lo(); xfer(8'h02, d); send_addr(a);
    for (int i = 0; i < n; i++) xfer(dat[31-8*i -: 8], d);
    cs_hi();
  endtask

  task automatic se(input logic [23:0] a);
    logic [7:0] d;
    cs_lo(); xfer(8'h20, d); send_addr(a); cs_hi();
  endtask

  task automatic wait_idle();
    logic [7:0] s;
    for (int i = 0; i < 200; i++) begin
      rdsr(s);
      if (!s[0]) break;
    end
  endtask

  initial begin
    #(WDOG_CYC * 5);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s, d;
    #100; rst_ni = 1'b1; #100;

    chk("R12 miso idle", {7'b0, miso}, 8'h00);
    rdsr(s); chk("R12 R3 reset status", s, 8'h00);
    rd(8'h03, 24'h0, 1); chk("R12 reset array", rb[0], 8'hFF);

    // R10 R1: discovery table in both modes
    for (int v = 0; v < 6; v++) begin
      mode3 = VEC[v][32]; sck = mode3; #HP;
      rd(8'h5A, VEC[v][31:8], 1);
      chk("R10 R1 discovery", rb[0], VEC[v][7:0]);
    end
    mode3 = 1'b0; sck = 1'b0; #HP;
    rd(8'h5A, 24'h2, 3);
    chk("R10 seq", rb[0], 8'h44); chk("R10 seq", rb[1], 8'h50); chk("R10 seq", rb[2], 8'h04);

    // R4 framing of write enable
    cs_lo(); xbits(8'h06, 7, d); cs_hi();
    rdsr(s); chk("R4 7 bits", s, 8'h00);
    cs_lo(); xfer(8'h06, d); xbits(8'h00, 1, d); cs_hi();
    rdsr(s); chk("R4 9 bits", s, 8'h00);
    cmd1(8'h06);
    cs_lo(); xfer(8'h05, d);
    for (int i = 0; i < 3; i++) begin xfer(8'h00, s); chk("R3 R4 repeat status", s, 8'h02); end
    cs_hi();

    // R5 R8 page program with in-page wrap
    pp(24'd62, 32'h12345678, 4);
    rdsr(s); chk("R8 busy", s, 8'h03);
    wait_idle();
    rdsr(s); chk("R8 WEL cleared", s, 8'h00);
    rd(8'h03, 24'd62, 3);
    chk("R5 pp", rb[0], 8'h12); chk("R5 pp", rb[1], 8'h34); chk("R5 next page", rb[2], 8'hFF);
    rd(8'h03, 24'd32, 3);
    chk("R5 wrap", rb[0], 8'h56); chk("R5 wrap", rb[1], 8'h78); chk("R5 wrap", rb[2], 8'hFF);
    cmd1(8'h06); pp(24'd32, 32'hF0000000, 1); wait_idle();
    rd(8'h03, 24'd32, 1); chk("R5 and", rb[0], 8'h50);

    // R7 no write enable
    pp(24'd40, 32'h0, 1); se(24'd0); wait_idle();
    rd(8'h03, 24'd40, 1); chk("R7 pp dropped", rb[0], 8'hFF);
    rd(8'h03, 24'd32, 1); chk("R7 se dropped", rb[0], 8'h50);

    // R5 partial final byte
    cmd1(8'h06);
    cs_lo(); xfer(8'h02, d); send_addr(24'd41); xfer(8'h00, d); xbits(8'h00, 3, d); cs_hi();
    rdsr(s); chk("R5 partial keeps WEL", s, 8'h02);
    rd(8'h03, 24'd41, 1); chk("R5 partial no write", rb[0], 8'hFF);
    pp(24'd200, 32'h11000000, 1); wait_idle();

    // R6 partial and proper erase
    cmd1(8'h06);
    cs_lo(); xfer(8'h20, d); send_addr(24'h50); xbits(8'h00, 2, d); cs_hi();
    rdsr(s); chk("R6 partial keeps WEL", s, 8'h02);
    rd(8'h03, 24'd32, 1); chk("R6 partial no erase", rb[0], 8'h50);
    se(24'h50); wait_idle();
    rd(8'h03, 24'd32, 1); chk("R6 erased", rb[0], 8'hFF);
    rd(8'h03, 24'd62, 1); chk("R6 erased", rb[0], 8'hFF);
    rd(8'h03, 24'd200, 1); chk("R6 other sector", rb[0], 8'h11);

    // R9 commands during busy
    cmd1(8'h06); se(24'd130);
    rdsr(s); chk("R9 status while busy", s, 8'h03);
    rd(8'h03, 24'd200, 1); chk("R9 read ignored", rb[0], 8'h00);
    pp(24'd300, 32'h0, 1);
    wait_idle();
    rd(8'h03, 24'd200, 1); chk("R9 erase done", rb[0], 8'hFF);
    rd(8'h03, 24'd300, 1); chk("R9 pp ignored", rb[0], 8'hFF);

    // R2 R1 wrap at top, read in mode 3
    cmd1(8'h06); pp(24'd511, 32'hA1000000, 1); wait_idle();
    cmd1(8'h06); pp(24'd0, 32'hB2000000, 1); wait_idle();
    mode3 = 1'b1; sck = 1'b1; #HP;
    rd(8'h03, 24'd510, 3);
    chk("R2 R1 top", rb[0], 8'hFF); chk("R2 R1 top", rb[1], 8'hA1); chk("R2 R1 wrap", rb[2], 8'hB2);
    mode3 = 1'b0; sck = 1'b0; #HP;

    // R11 power-down
    cmd1(8'hB9);
    rd(8'h03, 24'd0, 1); chk("R11 read ignored", rb[0], 8'h00);
    cmd1(8'h06);
    cmd1(8'hAB);
    rdsr(s); chk("R11 WREN ignored", s, 8'h00);
    rd(8'h03, 24'd0, 1); chk("R11 released", rb[0], 8'hB2);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule